// File: doc/BRIEF.md
# Battery-Backed Domain Supply and Tamper Controller

This block controls a small always-on domain that can run from the main supply or from a backup battery. It watches a supply-good indication and moves the domain onto the battery when the main rail has been low for a programmed number of clock cycles. It moves the domain back once the rail has been good for the same number of cycles. While the system sits in its deepest sleep state, the move onto the battery is suppressed. A charging path for the battery is enabled only by software, and it is cut automatically while the domain runs from the battery. A second software bit picks the series resistor of that path.

The domain keeps a 128-byte backup store that any CPU can read and write through a simple synchronous register port. Three tamper inputs are synchronised and filtered. An accepted tamper event records the pin in a sticky flag and starts a hardware wipe that clears every byte, one byte per clock. This works the same way whether the domain is on the main supply or on the battery.

Two state machines do the work. The supply machine has the states MAIN and BATT. The transition MAIN to BATT, named GO_BATT, fires when the run of low samples reaches the limit and shutdown is not asserted. The transition BATT to MAIN, named GO_MAIN, fires when the run of good samples reaches the limit. The wipe machine has the states IDLE and RUN. The transition START, IDLE to RUN, fires on any accepted tamper. The transition RESTART, RUN to RUN with the pointer reset, fires on a new accepted tamper during a wipe. The transition DONE, RUN to IDLE, fires after the last byte is cleared.

Top module: `bkd_ctrl`

## Requirements
- R1: After reset: `on_battery`=0, `charge_en`=0, `charge_low_r`=0, all backup bytes read 0, the tamper flags read 0, and the hysteresis register (address 129) reads 4.
- R2: Addresses 0 to 127 (address bit 7 = 0) hold the backup bytes. A write with `reg_we`=1 takes effect at the clock edge. `reg_rdata` shows the byte at `reg_addr` combinationally.
- R3: `supply_good` passes through a two-flop synchroniser. When the synchronised value has been low for H consecutive cycles in MAIN, the controller goes to BATT. H is the value at address 129; H=0 acts as 1. Shorter low runs cause no switch.
- R4: In BATT, H consecutive synchronised good samples return the controller to MAIN.
- R5: While `shutdown_mode`=1, the controller does not leave MAIN, and the count of low samples is held at zero.
- R6: Address 128 bit 0 is the charge request and bit 1 is the resistor select (1 = low-value 1.5 kΩ path, 0 = 5 kΩ path). `charge_en` equals the request while in MAIN and is 0 in BATT. `charge_low_r` follows bit 1.
- R7: Each `tamper_in` pin passes through a two-flop synchroniser. A tamper is accepted only when two consecutive synchronised samples are high, so a one-cycle pulse is ignored.
- R8: Address 130 bits [2:0] are sticky per-pin tamper flags (bit i = `tamper_in[i]`). Writing 1 to a bit clears it. A tamper accepted in the same cycle wins over the clear.
- R9: An accepted tamper clears all 128 bytes within 128 cycles. During the wipe, backup reads return 0 and backup writes are dropped. A new tamper restarts the wipe.
- R10: Tamper acceptance and wiping also operate while the domain is in BATT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register address: 0-127 backup bytes, 128 charge control, 129 hysteresis, 130 tamper flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tamper_in | input | 3 | Tamper detector inputs, active high, asynchronous |
| supply_good | input | 1 | Main supply above threshold, asynchronous |
| shutdown_mode | input | 1 | System is in its deepest sleep state |
| on_battery | output | 1 | Domain supply select: 1 = battery |
| charge_en | output | 1 | Battery charge path enable |
| charge_low_r | output | 1 | Charge resistor select: 1 = 1.5 kΩ, 0 = 5 kΩ |

## Verification
Two collisions matter most. The first is a software write to a backup byte or to the flag register in the same cycle that a tamper is accepted. The bench holds a tamper pin high while it issues a flag-clear write and a backup write. The flag must survive the clear, and the written byte must end up wiped. The second is a tamper wipe that runs while the supply machine is in BATT and the supply is switching. The bench fires a tamper with the domain on the battery. A cycle-accurate reference model is compared on every clock for the select, charge and read-data outputs.

// File: rtl/bkd_pkg.sv
package bkd_pkg;
    typedef enum logic {
        SUP_MAIN,
        SUP_BATT
    } sup_state_t;

    typedef enum logic {
        WIPE_IDLE,
        WIPE_RUN
    } wipe_state_t;

    localparam logic [1:0] CTL_OFF_CHARGE = 2'd0;
    localparam logic [1:0] CTL_OFF_HYST   = 2'd1;
    localparam logic [1:0] CTL_OFF_FLAGS  = 2'd2;
endpackage

// File: rtl/bkd_supply_sw.sv
module bkd_supply_sw
    import bkd_pkg::*;
#(
    parameter int HYST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_good,
    input  logic              shutdown_mode,
    input  logic [HYST_W-1:0] hyst,
    output logic              on_battery
);
    logic              sg_meta, sg_sync;
    sup_state_t        state, state_nx;
    logic [HYST_W-1:0] run_cnt, run_cnt_nx;
    logic [HYST_W:0]   lim, cnt_inc;

    assign lim     = (hyst == '0) ? {{HYST_W{1'b0}}, 1'b1} : {1'b0, hyst};
    assign cnt_inc = {1'b0, run_cnt} + 1'b1;

    always_comb begin
        state_nx   = state;
        run_cnt_nx = '0;
        unique case (state)
            SUP_MAIN: begin
                if (!sg_sync && !shutdown_mode) begin
                    if (cnt_inc >= lim) state_nx = SUP_BATT;
                    else                run_cnt_nx = run_cnt + 1'b1;
                end
            end
            SUP_BATT: begin
                if (sg_sync) begin
                    if (cnt_inc >= lim) state_nx = SUP_MAIN;
                    else                run_cnt_nx = run_cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sg_meta <= 1'b1;
            sg_sync <= 1'b1;
            state   <= SUP_MAIN;
            run_cnt <= '0;
        end else begin
            sg_meta <= supply_good;
            sg_sync <= sg_meta;
            state   <= state_nx;
            run_cnt <= run_cnt_nx;
        end
    end

    always_comb begin
        on_battery = (state == SUP_BATT);
    end
endmodule

// File: rtl/bkd_tamper_sync.sv
module bkd_tamper_sync #(
    parameter int NTAMP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAMP-1:0] tamper_in,
    output logic [NTAMP-1:0] accept
);
    for (genvar i = 0; i < NTAMP; i++) begin : g_pin
        logic s1, s2, s3;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                s3 <= 1'b0;
            end else begin
                s1 <= tamper_in[i];
                s2 <= s1;
                s3 <= s2;
            end
        end
        assign accept[i] = s2 & s3;
    end
endmodule

// File: rtl/bkd_regfile.sv
module bkd_regfile
    import bkd_pkg::*;
#(
    parameter int NBYTES = 128,
    localparam int IW    = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wipe_req,
    input  logic          wr_en,
    input  logic [IW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          busy
);
    localparam logic [IW-1:0] LAST = IW'(NBYTES - 1);

    logic [7:0]    mem [NBYTES];
    wipe_state_t   state, state_nx;
    logic [IW-1:0] ptr;

    always_comb begin
        state_nx = state;
        unique case (state)
            WIPE_IDLE: if (wipe_req) state_nx = WIPE_RUN;
            WIPE_RUN:  if (!wipe_req && ptr == LAST) state_nx = WIPE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WIPE_IDLE;
            ptr   <= '0;
        end else begin
            state <= state_nx;
            if (wipe_req)               ptr <= '0;
            else if (state == WIPE_RUN) ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= 8'h00;
        end else if (state == WIPE_RUN) begin
            mem[ptr] <= 8'h00;
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    always_comb begin
        busy  = (state == WIPE_RUN);
        rdata = busy ? 8'h00 : mem[addr];
    end
endmodule

// File: rtl/bkd_ctrl.sv
module bkd_ctrl
    import bkd_pkg::*;
#(
    parameter int NBYTES   = 128,
    parameter int NTAMP    = 3,
    parameter int HYST_W   = 8,
    parameter int HYST_RST = 4,
    localparam int IW      = $clog2(NBYTES),
    localparam int AW      = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [NTAMP-1:0] tamper_in,
    input  logic             supply_good,
    input  logic             shutdown_mode,
    output logic             on_battery,
    output logic             charge_en,
    output logic             charge_low_r
);
    logic              ctl_sel, bank_sel;
    logic [1:0]        ctl_off;
    logic              chg_req, res_low;
    logic [HYST_W-1:0] hyst;
    logic [NTAMP-1:0]  tamp_flags, tamp_accept, flag_clr;
    logic [7:0]        bank_rdata;
    logic              wipe_busy;

    assign bank_sel = !reg_addr[AW-1];
    assign ctl_sel  = reg_addr[AW-1] && (reg_addr[AW-2:2] == '0);
    assign ctl_off  = reg_addr[1:0];
    assign flag_clr = (reg_we && ctl_sel && ctl_off == CTL_OFF_FLAGS)
                      ? reg_wdata[NTAMP-1:0] : '0;

    bkd_supply_sw #(.HYST_W(HYST_W)) u_supply (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_good   (supply_good),
        .shutdown_mode (shutdown_mode),
        .hyst          (hyst),
        .on_battery    (on_battery)
    );

    bkd_tamper_sync #(.NTAMP(NTAMP)) u_tamper (
        .clk       (clk),
        .rst_n     (rst_n),
        .tamper_in (tamper_in),
        .accept    (tamp_accept)
    );

    bkd_regfile #(.NBYTES(NBYTES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wipe_req (|tamp_accept),
        .wr_en    (reg_we && bank_sel),
        .addr     (reg_addr[IW-1:0]),
        .wdata    (reg_wdata),
        .rdata    (bank_rdata),
        .busy     (wipe_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chg_req    <= 1'b0;
            res_low    <= 1'b0;
            hyst       <= HYST_W'(HYST_RST);
            tamp_flags <= '0;
        end else begin
            if (reg_we && ctl_sel && ctl_off == CTL_OFF_CHARGE) begin
                chg_req <= reg_wdata[0];
                res_low <= reg_wdata[1];
            end
            if (reg_we && ctl_sel && ctl_off == CTL_OFF_HYST)
                hyst <= reg_wdata[HYST_W-1:0];
            tamp_flags <= (tamp_flags & ~flag_clr) | tamp_accept;
        end
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (bank_sel) begin
            reg_rdata = bank_rdata;
        end else if (ctl_sel) begin
            unique case (ctl_off)
                CTL_OFF_CHARGE: reg_rdata[1:0] = {res_low, chg_req};
                CTL_OFF_HYST:   reg_rdata[HYST_W-1:0] = hyst;
                CTL_OFF_FLAGS:  reg_rdata[NTAMP-1:0] = tamp_flags;
                default:        reg_rdata = 8'h00;
            endcase
        end
    end

    always_comb begin
        charge_en    = chg_req && !on_battery;
        charge_low_r = res_low;
    end
endmodule

// File: rtl/bkd_ctrl_chk.sv
module bkd_ctrl_chk #(
    parameter int AW     = 8,
    parameter int NTAMP  = 3,
    parameter int NBYTES = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [AW-1:0]    reg_addr,
    input logic             shutdown_mode,
    input logic             on_battery,
    input logic             charge_en,
    input logic [NTAMP-1:0] flags,
    input logic [NTAMP-1:0] accept,
    input logic             wipe_busy
);
    localparam logic [AW-1:0] FLAG_ADDR = {1'b1, (AW-1)'(2)};
    localparam int CW = $clog2(NBYTES) + 2;

    logic [CW-1:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      busy_run <= '0;
        else if (!wipe_busy || |accept)  busy_run <= '0;
        else                             busy_run <= busy_run + 1'b1;
    end

    assert_shutdown_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_battery && shutdown_mode) |=> !on_battery);

    assert_charge_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        on_battery |-> !charge_en);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == FLAG_ADDR) |=> ((flags & $past(flags)) == $past(flags)));

    assert_wipe_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_busy |-> (busy_run < CW'(NBYTES)));

    assert_flag_starts_wipe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & ~$past(flags))) |-> wipe_busy);
endmodule

bind bkd_ctrl bkd_ctrl_chk #(.AW(AW), .NTAMP(NTAMP), .NBYTES(NBYTES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .shutdown_mode (shutdown_mode),
    .on_battery    (on_battery),
    .charge_en     (charge_en),
    .flags         (tamp_flags),
    .accept        (tamp_accept),
    .wipe_busy     (wipe_busy)
);

// File: tb/test_bkd_ctrl.sv
module test_bkd_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic [2:0] tamper = 3'b000;
    logic       sg = 1'b1;
    logic       sd = 1'b0;
    logic       on_batt, chg_en, chg_low;

    always #4 clk = ~clk;

    bkd_ctrl i_bkd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .tamper_in(tamper),
        .supply_good(sg), .shutdown_mode(sd), .on_battery(on_batt),
        .charge_en(chg_en), .charge_low_r(chg_low)
    );

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // behavioural reference model
    int  m_sgq[$];
    int  m_batt = 0, m_run = 0, m_hyst = 4;
    int  m_chg = 0, m_res = 0, m_flags = 0;
    int  m_tq[3][$];
    int  m_busy = 0, m_ptr = 0;
    byte m_mem[128];

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_rdata();
        if (addr < 128) return m_busy ? 0 : int'(m_mem[addr[6:0]]) & 255;
        case (addr)
            8'd128: return m_chg | (m_res << 1);
            8'd129: return m_hyst;
            8'd130: return m_flags;
            default: return 0;
        endcase
    endfunction

    task automatic model_init();
        m_sgq = {1, 1};
        for (int p = 0; p < 3; p++) m_tq[p] = {0, 0, 0};
        m_batt = 0; m_run = 0; m_hyst = 4; m_chg = 0; m_res = 0;
        m_flags = 0; m_busy = 0; m_ptr = 0;
        for (int k = 0; k < 128; k++) m_mem[k] = 0;
    endtask

    task automatic compare();
        check(cur_req, "on_battery", int'(on_batt), m_batt);
        check(cur_req, "charge_en", int'(chg_en), (m_chg && !m_batt) ? 1 : 0);
        check(cur_req, "charge_low_r", int'(chg_low), m_res);
        check(cur_req, "reg_rdata", int'(rdata), exp_rdata());
    endtask

    task automatic cycle();
        int acc, lim, sg_old, old_busy;
        @(posedge clk);
        // tamper accepted when the two latest synchronised samples are high
        acc = 0;
        for (int p = 0; p < 3; p++)
            if (m_tq[p][1] && m_tq[p][2]) acc |= (1 << p);
        sg_old = m_sgq[1];
        lim = (m_hyst == 0) ? 1 : m_hyst;
        if (!m_batt) begin
            if (!sg_old && !sd) begin
                if (m_run + 1 >= lim) begin m_batt = 1; m_run = 0; end
                else m_run++;
            end else m_run = 0;
        end else begin
            if (sg_old) begin
                if (m_run + 1 >= lim) begin m_batt = 0; m_run = 0; end
                else m_run++;
            end else m_run = 0;
        end
        old_busy = m_busy;
        if (old_busy) m_mem[m_ptr] = 0;
        else if (we && addr < 128) m_mem[addr[6:0]] = byte'(wdata);
        if (acc != 0) begin m_busy = 1; m_ptr = 0; end
        else if (old_busy) begin
            if (m_ptr == 127) m_busy = 0; else m_ptr++;
        end
        if (we && addr == 8'd130) m_flags = m_flags & ~int'(wdata[2:0]);
        m_flags |= acc;
        if (we && addr == 8'd128) begin m_chg = wdata[0]; m_res = wdata[1]; end
        if (we && addr == 8'd129) m_hyst = wdata;
        void'(m_sgq.pop_back());
        m_sgq.push_front(int'(sg));
        for (int p = 0; p < 3; p++) begin
            void'(m_tq[p].pop_back());
            m_tq[p].push_front(int'(tamper[p]));
        end
        #3;
        compare();
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic wr(int a, int d);
        we = 1'b1; addr = 8'(a); wdata = 8'(d);
        cycle();
        we = 1'b0;
    endtask

    task automatic rd(int a);
        addr = 8'(a);
        cycle();
    endtask

    int cyc_count = 0;
    always @(posedge clk) begin
        cyc_count++;
        if (cyc_count > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=20000", cyc_count);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_init();
        addr = 8'd129;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        // R1: reset state
        check("R1", "on_battery", int'(on_batt), 0);
        check("R1", "charge_en", int'(chg_en), 0);
        check("R1", "charge_low_r", int'(chg_low), 0);
        check("R1", "hyst reset", int'(rdata), 4);
        rd(130);
        rd(0);

        cur_req = "R2";
        wr(5, 8'hA5); wr(127, 8'h3C); wr(0, 8'h11);
        rd(5); rd(127); rd(0); rd(64);

        cur_req = "R6";
        wr(128, 3); rd(128); idle(2);

        cur_req = "R3 R6";
        wr(129, 3);
        sg = 1'b0; idle(2); sg = 1'b1; idle(6);
        sg = 1'b0; idle(8);

        cur_req = "R4";
        sg = 1'b1; idle(2); sg = 1'b0; idle(3);
        sg = 1'b1; idle(8);

        cur_req = "R5";
        sd = 1'b1; sg = 1'b0; idle(20);
        sd = 1'b0; idle(8);

        cur_req = "R7";
        tamper = 3'b001; cycle(); tamper = 3'b000;
        idle(5); rd(130); rd(5);

        cur_req = "R10 R9";
        tamper = 3'b010; idle(3); tamper = 3'b000;
        rd(5); rd(127); idle(3);
        wr(0, 8'h77); rd(0);
        sg = 1'b1; idle(10); sg = 1'b0;
        idle(125);
        rd(0); rd(5); rd(127); rd(130);

        cur_req = "R8";
        wr(7, 8'h5A);
        tamper = 3'b010; idle(2);
        wr(130, 8'h02); wr(7, 8'h66);
        idle(2); tamper = 3'b000;
        rd(130); idle(135);
        rd(7); rd(130);
        wr(130, 8'h02); rd(130);

        cur_req = "R3";
        sg = 1'b1; idle(8);
        wr(129, 0);
        sg = 1'b0; idle(4); sg = 1'b1; idle(4);
        rd(129);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule